// File: doc/BRIEF.md
# Programmable Chip Select Address Decoder

This block turns a 32-bit bus address and a 4-bit function code into four active-low chip-select lines. Each of the four channels holds a base register and a mask register, which are written and read over a small register port. A channel's line goes low while a bus cycle is flagged valid, the channel is enabled, every unmasked address bit from 31 down to 8 equals the programmed base, every unmasked function-code bit equals the programmed code, and the cycle is not a CPU-space access that the channel has been told to ignore.

A mask bit turns the matching base bit into a don't-care, so a channel covers 2^(n+8) bytes where n is the number of set address-mask bits. The set bits need not form a low-order run, so one channel can answer in several separate windows. Address bits 7 to 0 never take part, which makes 256 bytes the smallest window. The outputs are combinational from the bus inputs and the stored registers. A register write takes effect from the clock edge that stores it.

Top module: `chip_sel_decoder`

## Requirements
- R1: Register select `reg_sel[0]` picks base (0) or mask (1), and `reg_sel[2:1]` picks the channel. A write on a rising clock edge with `reg_we` high stores the data. `reg_rdata` shows the selected register combinationally. Base layout: bits 31:8 address, bits 7:4 function code, bit 1 no-CPU-space, bit 0 enable; bits 3:2 read as 0. Mask layout: bits 31:8 address mask, bits 7:4 function-code mask; bits 3:0 read as 0.
- R2: With the strobe high, `cs_n[k]` is low exactly when channel k is enabled and `bus_addr[31:8]` equals the base on every bit whose mask bit is clear. Address bits 7:0 never affect the result.
- R3: Address-mask bits in any non-contiguous pattern make the channel answer in every region that pattern describes, and nowhere else.
- R4: The function code must equal the base's code field on every bit whose function-code mask bit is clear.
- R5: With its no-CPU-space bit set, a channel stays deasserted for function codes 4'h7 and 4'hF. With the bit clear, those codes decode like any other.
- R6: A channel whose enable bit is clear never asserts.
- R7: With `bus_strobe` low, all four outputs are high.
- R8: Reset clears the enable and no-CPU-space bits of every base register and leaves all other base and mask bits unchanged. All outputs stay high while reset is applied.
- R9: When several channels match the same cycle, all of them assert together.
- R10: The mask register can be rewritten while a bus cycle is active, and the decode uses the new mask from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Channel in bits 2:1; base or mask in bit 0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| bus_addr | input | 32 | Bus cycle address |
| bus_fc | input | 4 | Bus cycle function code |
| bus_strobe | input | 1 | High while the bus cycle's address and code are valid |
| cs_n | output | 4 | Active-low chip selects, one per channel |

## Verification
The properties assume that `reg_sel`, `reg_we` and the bus inputs are known and settled at each rising edge, and that every register access names one of the four existing channels. The bench meets this by changing every input only on the falling edge, and by using only in-range selects with one write at a time. No decode check depends on bits that were never written after power-up: every channel is programmed before its line is examined.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int ADDR_W    = 32;
    localparam int FC_W      = 4;
    localparam int CMP_LSB   = 8;
    localparam int FC_LSB    = 4;
    localparam int EN_BIT    = 0;
    localparam int NOCPU_BIT = 1;

    localparam logic [ADDR_W-1:0] BASE_RW = 32'hFFFF_FFF3;
    localparam logic [ADDR_W-1:0] MASK_RW = 32'hFFFF_FFF0;

    function automatic logic is_cpu_space(input logic [FC_W-1:0] fc);
        return fc[2:0] == 3'b111;
    endfunction
endpackage

// File: rtl/cs_chan_regs.sv
module cs_chan_regs
    import cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_base,
    input  logic              we_mask,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] mask_o
);
    logic [ADDR_W-1:CMP_LSB] base_addr_q;
    logic [FC_W-1:0]         base_fc_q;
    logic [ADDR_W-1:CMP_LSB] mask_addr_q;
    logic [FC_W-1:0]         mask_fc_q;
    logic                    en_q;
    logic                    nocpu_q;

    // control flags: cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            nocpu_q <= 1'b0;
        end else if (we_base) begin
            en_q    <= wdata[EN_BIT];
            nocpu_q <= wdata[NOCPU_BIT];
        end
    end

    // address and code fields: kept across reset
    always_ff @(posedge clk) begin
        if (we_base) begin
            base_addr_q <= wdata[ADDR_W-1:CMP_LSB];
            base_fc_q   <= wdata[FC_LSB+FC_W-1:FC_LSB];
        end
        if (we_mask) begin
            mask_addr_q <= wdata[ADDR_W-1:CMP_LSB];
            mask_fc_q   <= wdata[FC_LSB+FC_W-1:FC_LSB];
        end
    end

    assign base_o = {base_addr_q, base_fc_q, 2'b00, nocpu_q, en_q};
    assign mask_o = {mask_addr_q, mask_fc_q, 4'b0000};
endmodule

// File: rtl/cs_chan_match.sv
module cs_chan_match
    import cs_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [FC_W-1:0]   fc_i,
    input  logic              strobe_i,
    output logic              hit_o
);
    logic addr_ok;
    logic fc_ok;
    logic cpu_block;

    always_comb begin
        addr_ok   = ((addr_i[ADDR_W-1:CMP_LSB] ^ base_i[ADDR_W-1:CMP_LSB])
                     & ~mask_i[ADDR_W-1:CMP_LSB]) == '0;
        fc_ok     = ((fc_i ^ base_i[FC_LSB+FC_W-1:FC_LSB])
                     & ~mask_i[FC_LSB+FC_W-1:FC_LSB]) == '0;
        cpu_block = base_i[NOCPU_BIT] && is_cpu_space(fc_i);
        hit_o     = strobe_i && base_i[EN_BIT] && addr_ok && fc_ok && !cpu_block;
    end
endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
    import cs_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [CHW:0]      reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FC_W-1:0]   bus_fc,
    input  logic              bus_strobe,
    output logic [NCH-1:0]    cs_n
);
    logic [NCH-1:0][ADDR_W-1:0] base_q;
    logic [NCH-1:0][ADDR_W-1:0] mask_q;
    logic [NCH-1:0]             hit;
    logic [CHW-1:0]             sel_ch;

    assign sel_ch = reg_sel[CHW:1];

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic we_b;
        logic we_m;
        assign we_b = reg_we && (sel_ch == CHW'(k)) && !reg_sel[0];
        assign we_m = reg_we && (sel_ch == CHW'(k)) &&  reg_sel[0];

        cs_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_base (we_b),
            .we_mask (we_m),
            .wdata   (reg_wdata),
            .base_o  (base_q[k]),
            .mask_o  (mask_q[k])
        );

        cs_chan_match u_match (
            .base_i   (base_q[k]),
            .mask_i   (mask_q[k]),
            .addr_i   (bus_addr),
            .fc_i     (bus_fc),
            .strobe_i (bus_strobe),
            .hit_o    (hit[k])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NCH; k++) begin
            if (sel_ch == CHW'(k))
                reg_rdata = reg_sel[0] ? mask_q[k] : base_q[k];
        end
    end

    assign cs_n = ~hit;
endmodule

// File: rtl/chip_sel_decoder_chk.sv
module chip_sel_decoder_chk
    import cs_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we,
    input logic [CHW:0]               reg_sel,
    input logic [ADDR_W-1:0]          reg_wdata,
    input logic [ADDR_W-1:0]          reg_rdata,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [FC_W-1:0]            bus_fc,
    input logic                       bus_strobe,
    input logic [NCH-1:0]             cs_n,
    input logic [NCH-1:0][ADDR_W-1:0] base_q,
    input logic [NCH-1:0][ADDR_W-1:0] mask_q
);
    // R8: outputs quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (cs_n == '1);
        end
    end

    a_r7_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> cs_n == '1);

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !base_q[k][EN_BIT] |-> cs_n[k]);

        a_r5_cpu_space_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            (base_q[k][NOCPU_BIT] && (bus_fc == 4'h7 || bus_fc == 4'hF)) |-> cs_n[k]);

        a_r2_addr_agrees: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[k] |-> (((bus_addr ^ base_q[k]) & ~mask_q[k]) >> CMP_LSB) == '0);

        a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_sel == {CHW'(k), 1'b1}) |=> mask_q[k] == ($past(reg_wdata) & MASK_RW));

        a_r1_base_write: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_sel == {CHW'(k), 1'b0}) |=> base_q[k] == ($past(reg_wdata) & BASE_RW));
    end
endmodule

bind chip_sel_decoder chip_sel_decoder_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .bus_addr   (bus_addr),
    .bus_fc     (bus_fc),
    .bus_strobe (bus_strobe),
    .cs_n       (cs_n),
    .base_q     (base_q),
    .mask_q     (mask_q)
);

// File: tb/sim_chip_sel_decoder.sv
`timescale 1ns/1ps
module sim_chip_sel_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_fc = '0;
    logic        bus_strobe = 1'b0;
    logic [3:0]  cs_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chip_sel_decoder u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
        .bus_fc(bus_fc), .bus_strobe(bus_strobe), .cs_n(cs_n)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic is_mask, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = {ch, is_mask}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] ch, input logic is_mask,
                          input logic [31:0] exp);
        reg_sel = {ch, is_mask};
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic bus_chk(input string req, input logic [31:0] a, input logic [3:0] fc,
                           input logic [3:0] exp);
        bus_addr = a; bus_fc = fc; bus_strobe = 1'b1;
        #1;
        chk(req, {28'd0, cs_n}, {28'd0, exp});
    endtask

    task automatic t_reset_state;
        bus_chk("R8 quiet after reset", 32'h0000_0000, 4'h0, 4'hF);
        for (int c = 0; c < 4; c++) begin
            reg_sel = {c[1:0], 1'b0};
            #1;
            chk("R8 flags clear", {30'd0, reg_rdata[1:0]}, 32'd0);
        end
    endtask

    task automatic t_reg_access;
        wr(2'd0, 1'b0, 32'h1234_56FF);
        rd_chk("R1 base readback", 2'd0, 1'b0, 32'h1234_56F3);
        wr(2'd0, 1'b1, 32'h000F_00FF);
        rd_chk("R1 mask readback", 2'd0, 1'b1, 32'h000F_00F0);
    endtask

    task automatic t_basic;
        bus_strobe = 1'b0;
        wr(2'd0, 1'b0, 32'h0010_0001);
        wr(2'd0, 1'b1, 32'h0000_00F0);
        bus_chk("R2 hit low bits ignored", 32'h0010_00AB, 4'h3, 4'b1110);
        bus_chk("R2 miss next page", 32'h0010_0100, 4'h3, 4'b1111);
        bus_strobe = 1'b0;
        #1;
        chk("R7 strobe low", {28'd0, cs_n}, 32'h0000_000F);
    endtask

    task automatic t_split_mask;
        wr(2'd1, 1'b0, 32'h2000_0001);
        wr(2'd1, 1'b1, 32'h0100_0FF0);
        bus_chk("R3 lower region", 32'h2000_0FFF, 4'h1, 4'b1101);
        bus_chk("R3 upper region", 32'h2100_0ABC, 4'h1, 4'b1101);
        bus_chk("R3 gap", 32'h2000_1000, 4'h1, 4'b1111);
        bus_chk("R3 outside", 32'h2200_0000, 4'h1, 4'b1111);
    endtask

    task automatic t_fc_match;
        wr(2'd2, 1'b0, 32'h3000_0051);
        wr(2'd2, 1'b1, 32'h0000_0020);
        bus_chk("R4 exact code", 32'h3000_0000, 4'h5, 4'b1011);
        bus_chk("R4 masked bit", 32'h3000_0000, 4'h7, 4'b1011);
        bus_chk("R4 code miss", 32'h3000_0000, 4'h6, 4'b1111);
        bus_chk("R4 code miss high", 32'h3000_0000, 4'hD, 4'b1111);
    endtask

    task automatic t_cpu_space;
        wr(2'd3, 1'b0, 32'h4000_00F3);
        wr(2'd3, 1'b1, 32'h0000_00F0);
        bus_chk("R5 blocked 7", 32'h4000_0000, 4'h7, 4'b1111);
        bus_chk("R5 blocked F", 32'h4000_0000, 4'hF, 4'b1111);
        bus_chk("R5 other code", 32'h4000_0000, 4'h6, 4'b0111);
        wr(2'd3, 1'b0, 32'h4000_00F1);
        bus_chk("R5 allowed 7", 32'h4000_0000, 4'h7, 4'b0111);
        wr(2'd3, 1'b0, 32'h4000_00F0);
        bus_chk("R6 disabled", 32'h4000_0000, 4'h7, 4'b1111);
    endtask

    task automatic t_overlap_and_mask_live;
        wr(2'd0, 1'b0, 32'h5000_0001);
        wr(2'd0, 1'b1, 32'h00FF_FFF0);
        wr(2'd1, 1'b0, 32'h5010_0001);
        wr(2'd1, 1'b1, 32'h0000_FFF0);
        bus_chk("R9 both hit", 32'h5010_0020, 4'h5, 4'b1100);
        bus_chk("R9 one hit", 32'h5020_0000, 4'h5, 4'b1110);
        wr(2'd0, 1'b1, 32'h0000_00F0);
        #1;
        chk("R10 live mask write", {28'd0, cs_n}, 32'h0000_000F);
        rd_chk("R10 mask readback", 2'd0, 1'b1, 32'h0000_00F0);
    endtask

    task automatic t_reset_keeps;
        @(negedge clk);
        rst_n = 1'b0;
        bus_chk("R8 quiet in reset", 32'h5010_0020, 4'h5, 4'b1111);
        @(negedge clk);
        rst_n = 1'b1;
        bus_chk("R8 disabled after reset", 32'h5010_0020, 4'h5, 4'b1111);
        rd_chk("R8 base kept", 2'd1, 1'b0, 32'h5010_0000);
        rd_chk("R8 mask kept", 2'd1, 1'b1, 32'h0000_FFF0);
        rd_chk("R8 fc kept", 2'd3, 1'b0, 32'h4000_00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reg_access();
        t_basic();
        t_split_mask();
        t_fc_match();
        t_cpu_space();
        t_overlap_and_mask_live();
        t_reset_keeps();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule